// File: doc/BRIEF.md
# Word-Serial Montgomery Modular Multiplier

This block computes the Montgomery product R = X * Y * 2^-N mod M for N-bit operands. Each operand is stored as E = N/W words of W bits. The datapath is one word wide. An outer loop takes one bit of X per iteration, starting from the least significant bit. An inner loop walks the words of Y, M and the running partial sum S. It keeps one carry for the multiplicand addition and a separate carry for the modulus addition.

Bit 0 of the new low word of S decides once per outer iteration whether M is added across all the words. As each word is produced, the previous word is rewritten with its bits moved one place down. Bit 0 of the new word fills the freed top position, which shifts S right by one bit across the word boundaries.

Software writes X, Y and M one word at a time through a word-wide write port, then pulses start. While the block runs, busy is high. A one-cycle done pulse marks the end of the run. After the outer loop, the block compares S with M and subtracts M once if S is not smaller. The fully reduced result is then read one word at a time through a registered read port.

Top module: `montmul_word`

## Requirements
- R1: For an odd M and X, Y below M, the result read after done equals X*Y*2^-N mod M. Word k of every operand and of the result holds bits k*W up to k*W+W-1.
- R2: The result is fully reduced: it is below M, and the extra top word at index E reads as zero.
- R3: When busy is low, a write with ld_en high stores ld_data into word ld_idx of the operand chosen by ld_sel (0 = X, 1 = Y, 2 = M). A write with ld_sel = 3 or with ld_idx of E or more changes no operand.
- R4: While busy is high, ld_en has no effect: the result of the running multiplication is unchanged, whatever is written during the run.
- R5: A start pulse while busy is high is ignored. The run keeps its length, done pulses once, and no second run follows.
- R6: In idle, start raises busy in the next cycle. Busy stays high until done. Done is a single-cycle pulse that appears in the same cycle that busy falls.
- R7: Done is asserted N*(E+2)+E+1 cycles after the clock edge that accepts start, or E+1 cycles later when the final subtraction is needed.
- R8: rd_data shows result word rd_idx one cycle after rd_idx is presented. While the block stays idle, the result holds.
- R9: After synchronous reset, busy and done are low.
- R10: The operands persist after a run, so a second start without new loads gives the same result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication when idle |
| ld_en | input | 1 | Operand word write enable |
| ld_sel | input | 2 | Operand select: 0 X, 1 Y, 2 M |
| ld_idx | input | IDX_W | Operand word index |
| ld_data | input | WORD_W | Operand word value |
| rd_idx | input | IDX_W | Result word index |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | WORD_W | Registered result word |

## Verification
The checks rely on three conditions. M must be odd. X and Y must be below M, so that the unreduced sum stays under 2M, the top carries vanish and a single subtraction is enough. The result must not be read while busy is high. The stimulus meets these conditions by sweeping X and Y only over the range 0 to M-1, including M-1 itself, for a set of odd moduli between 3 and 255. It reads the result only after done.

Writes to the operand store and start pulses issued during a run are deliberately allowed. The bench then shows that they do not disturb the run or its timing.

// File: rtl/mont_pkg.sv
package mont_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_CMP  = 2'd2,
    ST_SUB  = 2'd3
  } mont_state_e;

  localparam int unsigned BANKS = 3;
endpackage

// File: rtl/mont_opfile.sv
module mont_opfile #(
  parameter int W     = 4,
  parameter int E     = 2,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [IDX_W-1:0] widx,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] x_idx,
  input  logic [IDX_W-1:0] ym_idx,
  output logic [W-1:0]     x_word,
  output logic [W-1:0]     y_word,
  output logic [W-1:0]     m_word
);
  import mont_pkg::*;

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] NW = IDX_W'(E);

  logic [W-1:0] bank_q [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [W-1:0]     mem [DEPTH];
    logic [IDX_W-1:0] ridx;

    always_ff @(posedge clk) begin
      if (we && sel == 2'(b) && widx < NW)
        mem[widx] <= wdata;
    end

    assign ridx      = (b == 0) ? x_idx : ym_idx;
    assign bank_q[b] = (ridx < NW) ? mem[ridx] : '0;
  end

  assign x_word = bank_q[0];
  assign y_word = bank_q[1];
  assign m_word = bank_q[2];
endmodule

// File: rtl/mont_acc.sv
module mont_acc #(
  parameter int W     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [W-1:0]     rdata,
  input  logic [IDX_W-1:0] out_idx,
  output logic [W-1:0]     out_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[widx] <= wdata;
    out_data <= mem[out_idx];
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/mont_wordpe.sv
module mont_wordpe #(
  parameter int W = 4
) (
  input  logic [W-1:0] s_word,
  input  logic [W-1:0] y_word,
  input  logic [W-1:0] m_word,
  input  logic         xi,
  input  logic         first,
  input  logic         ca_in,
  input  logic         cb_in,
  input  logic         q_in,
  input  logic         bw_in,
  output logic [W-1:0] sum,
  output logic         ca_out,
  output logic         cb_out,
  output logic         q_out,
  output logic [W-1:0] diff,
  output logic         bw_out
);
  logic [W:0] t_ext;
  logic [W:0] u_ext;
  logic [W:0] d_ext;
  logic       ca_eff;
  logic       cb_eff;
  logic       bw_eff;

  always_comb begin
    ca_eff = first ? 1'b0 : ca_in;
    cb_eff = first ? 1'b0 : cb_in;
    bw_eff = first ? 1'b0 : bw_in;

    t_ext  = {1'b0, s_word} + (xi ? {1'b0, y_word} : '0) + {{W{1'b0}}, ca_eff};
    q_out  = first ? t_ext[0] : q_in;
    u_ext  = {1'b0, t_ext[W-1:0]} + (q_out ? {1'b0, m_word} : '0) + {{W{1'b0}}, cb_eff};
    d_ext  = {1'b0, s_word} - {1'b0, m_word} - {{W{1'b0}}, bw_eff};

    ca_out = t_ext[W];
    cb_out = u_ext[W];
    sum    = u_ext[W-1:0];
    diff   = d_ext[W-1:0];
    bw_out = d_ext[W];
  end
endmodule

// File: rtl/mont_ctrl.sv
module mont_ctrl #(
  parameter int N     = 8,
  parameter int W     = 4,
  parameter int E     = 2,
  parameter int IDX_W = 2,
  parameter int CNT_W = 3,
  parameter int BIT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [W-1:0]     x_word,
  input  logic [W-1:0]     sum,
  input  logic             ca_out,
  input  logic             cb_out,
  input  logic             q_out,
  input  logic [W-1:0]     diff,
  input  logic             bw_out,
  output logic [IDX_W-1:0] x_idx,
  output logic [IDX_W-1:0] wd_idx,
  output logic             xi,
  output logic             first,
  output logic             s_zero,
  output logic             ca_q,
  output logic             cb_q,
  output logic             q_q,
  output logic             bw_q,
  output logic             acc_we,
  output logic [IDX_W-1:0] acc_widx,
  output logic [W-1:0]     acc_wdata,
  output logic             busy,
  output logic             done
);
  import mont_pkg::*;

  localparam logic [IDX_W-1:0] J_TOP   = IDX_W'(E);
  localparam logic [IDX_W-1:0] J_SHIFT = IDX_W'(E + 1);
  localparam logic [CNT_W-1:0] I_LAST  = CNT_W'(N - 1);

  mont_state_e      st;
  logic [CNT_W-1:0] bit_i;
  logic [IDX_W-1:0] word_j;
  logic [W-1:1]     prev_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      bit_i   <= '0;
      word_j  <= '0;
      ca_q    <= 1'b0;
      cb_q    <= 1'b0;
      q_q     <= 1'b0;
      bw_q    <= 1'b0;
      prev_hi <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            st     <= ST_MUL;
            bit_i  <= '0;
            word_j <= '0;
          end
        end
        ST_MUL: begin
          if (word_j == J_SHIFT) begin
            word_j <= '0;
            if (bit_i == I_LAST) st <= ST_CMP;
            else                 bit_i <= bit_i + CNT_W'(1);
          end else begin
            ca_q    <= ca_out;
            cb_q    <= cb_out;
            q_q     <= q_out;
            prev_hi <= sum[W-1:1];
            word_j  <= word_j + IDX_W'(1);
          end
        end
        ST_CMP: begin
          bw_q <= bw_out;
          if (word_j == J_TOP) begin
            word_j <= '0;
            if (bw_out) begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end else begin
              st <= ST_SUB;
            end
          end else begin
            word_j <= word_j + IDX_W'(1);
          end
        end
        ST_SUB: begin
          bw_q <= bw_out;
          if (word_j == J_TOP) begin
            word_j <= '0;
            st     <= ST_IDLE;
            done   <= 1'b1;
          end else begin
            word_j <= word_j + IDX_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    x_idx  = IDX_W'(bit_i >> BIT_W);
    xi     = x_word[bit_i[BIT_W-1:0]];
    wd_idx = word_j;
    first  = (word_j == '0);
    s_zero = (st == ST_MUL) && (bit_i == '0);
    busy   = (st != ST_IDLE);

    acc_we    = ((st == ST_MUL) && (word_j != '0)) || (st == ST_SUB);
    acc_widx  = (st == ST_SUB) ? word_j : word_j - IDX_W'(1);
    if (st == ST_SUB)
      acc_wdata = diff;
    else if (word_j == J_SHIFT)
      acc_wdata = {1'b0, prev_hi};
    else
      acc_wdata = {sum[0], prev_hi};
  end
endmodule

// File: rtl/montmul_word.sv
module montmul_word #(
  parameter int OP_W   = 8,
  parameter int WORD_W = 4,
  localparam int NWORDS = OP_W / WORD_W,
  localparam int IDX_W  = $clog2(NWORDS + 2),
  localparam int CNT_W  = $clog2(OP_W),
  localparam int BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ld_en,
  input  logic [1:0]        ld_sel,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [WORD_W-1:0] ld_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rd_data
);
  logic [IDX_W-1:0]  x_idx, wd_idx, acc_widx;
  logic [WORD_W-1:0] x_word, y_word, m_word, s_rdata, s_in;
  logic [WORD_W-1:0] sum, diff, acc_wdata;
  logic xi, first, s_zero, ca_q, cb_q, q_q, bw_q;
  logic ca_out, cb_out, q_out, bw_out, acc_we;

  mont_opfile #(.W(WORD_W), .E(NWORDS), .IDX_W(IDX_W)) u_ops (
    .clk   (clk),
    .we    (ld_en & ~busy),
    .sel   (ld_sel),
    .widx  (ld_idx),
    .wdata (ld_data),
    .x_idx (x_idx),
    .ym_idx(wd_idx),
    .x_word(x_word),
    .y_word(y_word),
    .m_word(m_word)
  );

  mont_acc #(.W(WORD_W), .IDX_W(IDX_W)) u_acc (
    .clk     (clk),
    .we      (acc_we),
    .widx    (acc_widx),
    .wdata   (acc_wdata),
    .ridx    (wd_idx),
    .rdata   (s_rdata),
    .out_idx (rd_idx),
    .out_data(rd_data)
  );

  assign s_in = s_zero ? '0 : s_rdata;

  mont_wordpe #(.W(WORD_W)) u_pe (
    .s_word(s_in),
    .y_word(y_word),
    .m_word(m_word),
    .xi    (xi),
    .first (first),
    .ca_in (ca_q),
    .cb_in (cb_q),
    .q_in  (q_q),
    .bw_in (bw_q),
    .sum   (sum),
    .ca_out(ca_out),
    .cb_out(cb_out),
    .q_out (q_out),
    .diff  (diff),
    .bw_out(bw_out)
  );

  mont_ctrl #(
    .N(OP_W), .W(WORD_W), .E(NWORDS),
    .IDX_W(IDX_W), .CNT_W(CNT_W), .BIT_W(BIT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .x_word   (x_word),
    .sum      (sum),
    .ca_out   (ca_out),
    .cb_out   (cb_out),
    .q_out    (q_out),
    .diff     (diff),
    .bw_out   (bw_out),
    .x_idx    (x_idx),
    .wd_idx   (wd_idx),
    .xi       (xi),
    .first    (first),
    .s_zero   (s_zero),
    .ca_q     (ca_q),
    .cb_q     (cb_q),
    .q_q      (q_q),
    .bw_q     (bw_q),
    .acc_we   (acc_we),
    .acc_widx (acc_widx),
    .acc_wdata(acc_wdata),
    .busy     (busy),
    .done     (done)
  );
endmodule

// File: rtl/mont_chk.sv
module mont_chk #(
  parameter int W     = 4,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             acc_we,
  input logic [IDX_W-1:0] rd_idx,
  input logic [W-1:0]     rd_data
);
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);  // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);  // R6
  AST_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);  // R6
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !acc_we);  // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && !$past(busy, 2) &&
     ($past(rd_idx) == $past(rd_idx, 2))) |-> $stable(rd_data));  // R8
endmodule

bind montmul_word mont_chk #(.W(WORD_W), .IDX_W(IDX_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .acc_we (acc_we),
  .rd_idx (rd_idx),
  .rd_data(rd_data)
);

// File: tb/tb_montmul_word.sv
module tb_montmul_word;
  localparam int N     = 8;
  localparam int W     = 4;
  localparam int E     = N / W;
  localparam int IDX_W = $clog2(E + 2);
  localparam int MASK  = (1 << W) - 1;
  localparam int LAT0  = N * (E + 2) + E + 1;
  localparam int LAT1  = LAT0 + E + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic ld_en = 1'b0;
  logic [1:0] ld_sel = '0;
  logic [IDX_W-1:0] ld_idx = '0;
  logic [W-1:0] ld_data = '0;
  logic [IDX_W-1:0] rd_idx = '0;
  logic busy, done;
  logic [W-1:0] rd_data;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  montmul_word #(.OP_W(N), .WORD_W(W)) dut (
    .clk(clk), .rst(rst), .start(start),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_idx(ld_idx), .ld_data(ld_data),
    .rd_idx(rd_idx), .busy(busy), .done(done), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mont_ref(input int x, input int y, input int m);
    int half = (m + 1) / 2;
    int r = (x * y) % m;
    for (int k = 0; k < N; k++) r = (r * half) % m;
    return r;
  endfunction

  task automatic wr(input int sel, input int idx, input int data);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = 2'(sel); ld_idx = IDX_W'(idx); ld_data = W'(data);
    @(posedge clk);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic load_all(input int x, input int y, input int m);
    for (int k = 0; k < E; k++) begin
      wr(0, k, (x >> (k * W)) & MASK);
      wr(1, k, (y >> (k * W)) & MASK);
      wr(2, k, (m >> (k * W)) & MASK);
    end
  endtask

  task automatic read_res(output int res, output int top);
    res = 0;
    for (int k = 0; k <= E; k++) begin
      @(negedge clk);
      rd_idx = IDX_W'(k);
      @(posedge clk);
      @(negedge clk);
      if (k < E) res = res | (int'(rd_data) << (k * W));
      else       top = int'(rd_data);
    end
  endtask

  // mode 0: plain, 1: writes during run, 2: extra start during run
  task automatic run_chk(input int x, input int y, input int m, input int mode, input string tag);
    int cnt = 0;
    bit busy_ok = 1;
    int res, top, exp;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    while (cnt < 1000) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (done) break;
      if (!busy) busy_ok = 0;
      if (mode == 1 && cnt >= 3 && cnt < 3 + 3 * E) begin
        ld_en = 1'b1;
        ld_sel = 2'((cnt - 3) / E);
        ld_idx = IDX_W'((cnt - 3) % E);
        ld_data = W'(cnt * 5 + 7);
      end else begin
        ld_en = 1'b0;
      end
      start = (mode == 2 && cnt == 5);
    end
    ld_en = 1'b0;
    start = 1'b0;
    chk(busy_ok, {"R6 busy held ", tag}, int'(busy_ok), 1);
    chk(!busy, {"R6 busy low at done ", tag}, int'(busy), 0);
    chk(cnt == LAT0 || cnt == LAT1, {"R7 latency ", tag}, cnt, LAT0);
    read_res(res, top);
    exp = mont_ref(x, y, m);
    chk(res == exp, {"R1 product ", tag}, res, exp);
    chk(res < m && top == 0, {"R2 reduced ", tag}, res * 16 + top, exp * 16);
    if (mode == 2) begin
      bit quiet = 1;
      for (int k = 0; k < 2 * LAT1; k++) begin
        @(negedge clk);
        if (busy || done) quiet = 0;
      end
      chk(quiet, {"R5 no second run ", tag}, int'(quiet), 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL R7 watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int mods[6] = '{255, 171, 129, 97, 13, 3};
    int res, top;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9
    chk(!busy && !done, "R9 reset state", int'(busy) * 2 + int'(done), 0);

    // R3: loads with unused select or out-of-range index are dropped
    load_all(200, 123, 251);
    wr(3, 0, 9);
    wr(0, E, 15);
    wr(2, E, 15);
    run_chk(200, 123, 251, 0, "R3 ignored writes");

    // R10: rerun without reloading
    run_chk(200, 123, 251, 0, "R10 rerun");

    // R8: output holds while idle
    @(negedge clk);
    rd_idx = '0;
    repeat (4) @(negedge clk);
    chk(int'(rd_data) == (mont_ref(200, 123, 251) & MASK), "R8 hold", int'(rd_data),
        mont_ref(200, 123, 251) & MASK);

    // R4: writes during a run
    load_all(77, 250, 253);
    run_chk(77, 250, 253, 1, "R4 writes while busy");

    // R5: start while busy
    load_all(31, 9, 97);
    run_chk(31, 9, 97, 2, "R5 start while busy");

    // sweep over odd moduli, operands below M, edges X=0 and M-1
    foreach (mods[mi]) begin
      int m = mods[mi];
      int st = (m / 15 > 1) ? m / 15 : 1;
      for (int x = 0; x < m; x++) begin
        if (x % st != 0 && x != m - 1) continue;
        for (int y = 0; y < m; y++) begin
          if (y % st != 0 && y != m - 1) continue;
          load_all(x, y, m);
          run_chk(x, y, m, 0, "sweep");
        end
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule